// File: doc/BRIEF.md
# Pipeline Data Hazard Stall Unit

This unit sits between the instruction fetch stage and a five-stage in-order pipeline. On every cycle it looks at the 32-bit instruction that fetch presents. It works out which operand fields that instruction reads. It then compares those fields against the destination registers of the most recently issued instructions that write a register. If any of them has not yet reached the write-back point, the unit raises a stall to the fetch address register and sends an all-zero NOP word down the pipeline. It also captures the blocked instruction internally.

While stalled, the unit keeps pushing NOPs into its in-flight window, so the conflicting writer ages out by one slot per cycle. The bubble is therefore three, two or one NOP, depending on how close the writer was. When no conflict remains, the captured instruction is issued, the stall drops, and fetch resumes on the next cycle. The register file is expected to forward a write to a same-cycle read, so only the last `DEPTH` issued instructions (three by default) are examined.

Instruction layout: opcode in bits [31:24], destination field A in [23:16], first source field B in [15:8], second source field C in [7:0]. With the default 8-bit fields, the field width and the window depth are parameters.

Top module: `hazard_stall_unit`

## Requirements
- R1: The reset `rst` is synchronous and active high. In the first cycle after it is released, `stall_o` is low, no instruction is held, and every window slot counts as a NOP, whatever was stalled before.
- R2: An incoming instruction with opcode 0x01, 0x02 or 0x03 (add, multiply, subtract) conflicts if its field B (bits 15:8) or its field C (bits 7:0) equals the field A of any writer in the window.
- R3: An incoming instruction with opcode 0x05 (register copy) or 0x08 (store to memory) conflicts only through field B; its field C is ignored.
- R4: These incoming opcodes never cause a stall, whatever their fields hold: 0x06 (load immediate), 0x07 (load from memory), 0x00 (NOP) and any opcode not named in R2 or R3.
- R5: Only issued instructions with opcode 0x01, 0x02, 0x03, 0x05, 0x06 or 0x07 act as writers. An issued store, NOP or unlisted opcode never causes a conflict, even when its field A matches.
- R6: In a conflict cycle, `stall_o` is high in that same cycle and `issue_word_o` is 32'h00000000. Otherwise `stall_o` is low and `issue_word_o` carries the instruction that was checked.
- R7: With a single conflicting writer, the number of stall cycles is 3 if the writer was issued just before, 2 if one instruction lies between them, and 1 if two lie between them.
- R8: In every stall cycle after the first, `fetch_word_i` is ignored. The instruction issued when the stall drops is the one captured in the first stall cycle.
- R9: When several writers conflict, the bubble lasts until the nearest one leaves the window. A released instruction becomes a writer at once, so a dependent instruction that follows it gets a full 3-cycle bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_word_i | input | 32 | Instruction presented by fetch this cycle |
| stall_o | output | 1 | Hold the fetch address (high while a conflict exists) |
| issue_word_o | output | 32 | Instruction sent to the pipeline: checked instruction or NOP |

## Verification
The two functions that coincide are the release of a held instruction and its entry into the window as a new writer. In the cycle the last conflicting writer ages out, the captured instruction is issued and also becomes the newest producer. The bench provokes this by feeding an instruction that depends on the one just released, and judges that a fresh three-cycle bubble follows with no gap. A second overlap is a reset applied in the middle of a stall. The bench checks that the same dependent word then issues at once and that the held copy is gone.

// File: rtl/hz_pkg.sv
package hz_pkg;

   localparam int OPC_W = 8;

   localparam logic [OPC_W-1:0] OP_NOP   = 8'h00;
   localparam logic [OPC_W-1:0] OP_ADD   = 8'h01;
   localparam logic [OPC_W-1:0] OP_MUL   = 8'h02;
   localparam logic [OPC_W-1:0] OP_SUB   = 8'h03;
   localparam logic [OPC_W-1:0] OP_COPY  = 8'h05;
   localparam logic [OPC_W-1:0] OP_IMM   = 8'h06;
   localparam logic [OPC_W-1:0] OP_LOAD  = 8'h07;
   localparam logic [OPC_W-1:0] OP_STORE = 8'h08;

   // Which source fields an instruction reads
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_B    = 2'd1,
      SRC_BC   = 2'd2
   } src_sel_e;

   function automatic src_sel_e src_class(input logic [OPC_W-1:0] op);
      src_sel_e s;
      case (op)
         OP_ADD, OP_MUL, OP_SUB: s = SRC_BC;
         OP_COPY, OP_STORE:      s = SRC_B;
         default:                s = SRC_NONE;
      endcase
      return s;
   endfunction

   function automatic logic writes_dest(input logic [OPC_W-1:0] op);
      logic w;
      case (op)
         OP_ADD, OP_MUL, OP_SUB, OP_COPY, OP_IMM, OP_LOAD: w = 1'b1;
         default:                                         w = 1'b0;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/hz_decode.sv
module hz_decode
   import hz_pkg::*;
#(
   parameter int FIELD_W = 8,
   localparam int WORD_W = OPC_W + 3 * FIELD_W
) (
   input  logic [WORD_W-1:0]  word_i,
   output src_sel_e           src_o,
   output logic               prod_o,
   output logic [FIELD_W-1:0] fa_o,
   output logic [FIELD_W-1:0] fb_o,
   output logic [FIELD_W-1:0] fc_o
);

   localparam int C_LO = 0;
   localparam int B_LO = FIELD_W;
   localparam int A_LO = 2 * FIELD_W;
   localparam int O_LO = 3 * FIELD_W;

   logic [OPC_W-1:0] op;

   always_comb begin
      op     = word_i[O_LO +: OPC_W];
      fa_o   = word_i[A_LO +: FIELD_W];
      fb_o   = word_i[B_LO +: FIELD_W];
      fc_o   = word_i[C_LO +: FIELD_W];
      src_o  = src_class(op);
      prod_o = writes_dest(op);
   end

endmodule

// File: rtl/hz_tracker.sv
module hz_tracker #(
   parameter int FIELD_W = 8,
   parameter int DEPTH   = 3
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     push_prod_i,
   input  logic [FIELD_W-1:0]       push_dst_i,
   output logic [DEPTH-1:0]         prod_o,
   output logic [DEPTH*FIELD_W-1:0] dst_o
);

   logic [DEPTH-1:0]   prod_q;
   logic [FIELD_W-1:0] dst_q [DEPTH];

   // Slot 0 holds the most recently issued instruction
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst) begin
               prod_q[0] <= 1'b0;
               dst_q[0]  <= '0;
            end else begin
               prod_q[0] <= push_prod_i;
               dst_q[0]  <= push_dst_i;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (rst) begin
               prod_q[i] <= 1'b0;
               dst_q[i]  <= '0;
            end else begin
               prod_q[i] <= prod_q[i-1];
               dst_q[i]  <= dst_q[i-1];
            end
         end
      end
      assign dst_o[i*FIELD_W +: FIELD_W] = dst_q[i];
   end

   assign prod_o = prod_q;

   // R1: the window is empty of writers right after reset
   p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (prod_o == '0));

endmodule

// File: rtl/hz_match.sv
module hz_match
   import hz_pkg::*;
#(
   parameter int FIELD_W = 8,
   parameter int DEPTH   = 3
) (
   input  src_sel_e                 src_i,
   input  logic [FIELD_W-1:0]       fb_i,
   input  logic [FIELD_W-1:0]       fc_i,
   input  logic [DEPTH-1:0]         prod_i,
   input  logic [DEPTH*FIELD_W-1:0] dst_i,
   output logic                     hit_o
);

   logic [DEPTH-1:0] slot_hit;
   logic             use_b;
   logic             use_c;

   assign use_b = (src_i == SRC_B) || (src_i == SRC_BC);
   assign use_c = (src_i == SRC_BC);

   for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
      logic [FIELD_W-1:0] d;
      assign d = dst_i[i*FIELD_W +: FIELD_W];
      assign slot_hit[i] = prod_i[i] &
                           ((use_b && (fb_i == d)) || (use_c && (fc_i == d)));
   end

   assign hit_o = |slot_hit;

   // R5: with no writer in the window there is never a conflict
   always_comb begin
      if (prod_i == '0) begin
         p_no_writer_no_hit_r5: assert (!hit_o);
      end
   end

endmodule

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit
   import hz_pkg::*;
#(
   parameter int FIELD_W = 8,
   parameter int DEPTH   = 3,
   localparam int WORD_W = OPC_W + 3 * FIELD_W,
   localparam int RUN_W  = $clog2(DEPTH + 2)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] fetch_word_i,
   output logic              stall_o,
   output logic [WORD_W-1:0] issue_word_o
);

   if (FIELD_W < 1 || FIELD_W > 16) begin : g_bad_field
      $error("hazard_stall_unit: FIELD_W out of range");
   end
   if (DEPTH < 1 || DEPTH > 8) begin : g_bad_depth
      $error("hazard_stall_unit: DEPTH out of range");
   end

   logic              hold_q;
   logic [WORD_W-1:0] held_q;
   logic [WORD_W-1:0] cand;

   src_sel_e           c_src;
   logic               c_prod;
   logic [FIELD_W-1:0] c_fa, c_fb, c_fc;

   logic [DEPTH-1:0]         trk_prod;
   logic [DEPTH*FIELD_W-1:0] trk_dst;
   logic                     hit;

   // While holding, the captured word replaces the fetch input (R8)
   assign cand = hold_q ? held_q : fetch_word_i;

   hz_decode #(.FIELD_W(FIELD_W)) u_dec (
      .word_i (cand),
      .src_o  (c_src),
      .prod_o (c_prod),
      .fa_o   (c_fa),
      .fb_o   (c_fb),
      .fc_o   (c_fc)
   );

   hz_match #(.FIELD_W(FIELD_W), .DEPTH(DEPTH)) u_match (
      .src_i  (c_src),
      .fb_i   (c_fb),
      .fc_i   (c_fc),
      .prod_i (trk_prod),
      .dst_i  (trk_dst),
      .hit_o  (hit)
   );

   // A stall pushes a NOP slot; an issue pushes the word's writer info
   hz_tracker #(.FIELD_W(FIELD_W), .DEPTH(DEPTH)) u_trk (
      .clk         (clk),
      .rst         (rst),
      .push_prod_i (c_prod & ~hit),
      .push_dst_i  (hit ? '0 : c_fa),
      .prod_o      (trk_prod),
      .dst_o       (trk_dst)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= 1'b0;
         held_q <= '0;
      end else begin
         hold_q <= hit;
         if (hit) begin
            held_q <= cand;
         end
      end
   end

   assign stall_o      = hit;
   assign issue_word_o = hit ? '0 : cand;

   // Consecutive stall cycles, used to bound the bubble length
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= '0;
      end else if (!stall_o) begin
         run_q <= '0;
      end else if (run_q != '1) begin
         run_q <= run_q + 1'b1;
      end
   end

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !stall_o);

   p_nop_on_stall_r6: assert property (@(posedge clk) disable iff (rst)
      stall_o |-> (issue_word_o == '0));

   p_silent_class_r4: assert property (@(posedge clk) disable iff (rst)
      (c_src == SRC_NONE) |-> !stall_o);

   p_bubble_bound_r7: assert property (@(posedge clk) disable iff (rst)
      run_q <= RUN_W'(DEPTH));

   p_stall_pushes_nop_r6: assert property (@(posedge clk) disable iff (rst)
      stall_o |=> !trk_prod[0]);

   p_release_real_r8: assert property (@(posedge clk) disable iff (rst)
      $fell(stall_o) |-> (issue_word_o[WORD_W-1 -: OPC_W] != OP_NOP));

endmodule

// File: tb/hazard_stall_unit_tb.sv
`timescale 1ns/1ps
module hazard_stall_unit_tb;

   localparam logic [31:0] JUNK = 32'h02EE0000;
   localparam logic [31:0] NOPW = 32'h00000000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] fetch_word = '0;
   logic        stall;
   logic [31:0] issue_word;

   always #2.5 clk = ~clk;

   hazard_stall_unit u_dut (
      .clk          (clk),
      .rst          (rst),
      .fetch_word_i (fetch_word),
      .stall_o      (stall),
      .issue_word_o (issue_word)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   // Reference model state: window of last three issued instructions
   bit          m_wr  [3];
   logic [7:0]  m_dst [3];
   bit          m_hold;
   logic [31:0] m_held;

   function automatic bit is_writer(input logic [7:0] op);
      return (op == 8'h01 || op == 8'h02 || op == 8'h03 ||
              op == 8'h05 || op == 8'h06 || op == 8'h07);
   endfunction

   function automatic bit conflicts(input logic [31:0] w);
      bit rb, rc, h;
      rb = (w[31:24] inside {8'h01, 8'h02, 8'h03, 8'h05, 8'h08});
      rc = (w[31:24] inside {8'h01, 8'h02, 8'h03});
      h  = 1'b0;
      for (int k = 0; k < 3; k++) begin
         if (m_wr[k] && rb && w[15:8] == m_dst[k]) h = 1'b1;
         if (m_wr[k] && rc && w[7:0]  == m_dst[k]) h = 1'b1;
      end
      return h;
   endfunction

   task automatic model_clear();
      for (int k = 0; k < 3; k++) begin
         m_wr[k]  = 1'b0;
         m_dst[k] = '0;
      end
      m_hold = 1'b0;
      m_held = '0;
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // One clock: present a word, compare outputs, advance the model
   task automatic one_cycle(input logic [31:0] w, input string tag, output bit st);
      logic [31:0] cand;
      bit          h;
      @(negedge clk);
      fetch_word = m_hold ? JUNK : w;
      #1;
      cand = m_hold ? m_held : w;
      h    = conflicts(cand);
      check(stall == h, tag, "stall", {31'd0, stall}, {31'd0, h});
      check(issue_word == (h ? NOPW : cand), h ? "R6" : (m_hold ? "R8" : tag),
            "issue word", issue_word, h ? NOPW : cand);
      st = h;
      @(posedge clk);
      m_wr[2]  = m_wr[1];  m_dst[2] = m_dst[1];
      m_wr[1]  = m_wr[0];  m_dst[1] = m_dst[0];
      if (h) begin
         m_wr[0] = 1'b0; m_dst[0] = '0;
         m_hold  = 1'b1; m_held   = cand;
      end else begin
         m_wr[0] = is_writer(cand[31:24]); m_dst[0] = cand[23:16];
         m_hold  = 1'b0;
      end
   endtask

   task automatic feed(input logic [31:0] w, input string tag, inout int stalls);
      bit st;
      do begin
         one_cycle(w, tag, st);
         if (st) stalls++;
      end while (st);
   endtask

   task automatic segment(input string tag, input int n,
                          input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3,
                          input int exp_stalls);
      int s = 0;
      int f = 0;
      for (int k = 0; k < 3; k++) feed(NOPW, tag, f);
      if (n > 0) feed(w0, tag, s);
      if (n > 1) feed(w1, tag, s);
      if (n > 2) feed(w2, tag, s);
      if (n > 3) feed(w3, tag, s);
      check(s == exp_stalls, tag, "stall cycle count", s, exp_stalls);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      bit st;
      int s;
      model_clear();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #1;
      // R1: reset state
      check(stall == 1'b0, "R1", "stall after reset", {31'd0, stall}, 32'd0);
      check(issue_word == NOPW, "R1", "issue after reset", issue_word, NOPW);

      // R7: writer just before -> 3
      segment("R7", 3, 32'h06001200, 32'h06011200, 32'h01020100, NOPW, 3);
      // R7: one between -> 2 (copy reads B only)
      segment("R7", 3, 32'h01030000, 32'h05040500, 32'h05040300, NOPW, 2);
      // R7: two between -> 1 (store reads B)
      segment("R7", 4, 32'h05050100, 32'h06001200, 32'h06001200, 32'h08020500, 1);
      // R5: store and NOP slots are not writers
      segment("R5", 2, 32'h08070000, 32'h01090707, NOPW, NOPW, 0);
      segment("R5", 1, 32'h01090000, NOPW, NOPW, NOPW, 0);
      // R3: field C ignored for copy and store
      segment("R3", 3, 32'h06040000, 32'h050A0104, 32'h08000104, NOPW, 0);
      // R4: immediate, load and unlisted opcodes never stall
      segment("R4", 4, 32'h06050000, 32'h06060505, 32'h07070505, 32'h04080606, 0);
      // R2: match through field C, writer one back
      segment("R2", 3, 32'h060B0000, NOPW, 32'h010C000B, NOPW, 2);
      // R9: released word is a writer at once -> 3 + 3
      segment("R9", 4, 32'h06010000, 32'h06020000, 32'h01030201, 32'h01040303, 6);
      // R9: two matching writers, nearest one back sets 2
      segment("R9", 4, 32'h06010000, 32'h06020000, NOPW, 32'h02030102, 2);

      // R1: reset in the middle of a stall drops the held word
      s = 0;
      for (int k = 0; k < 3; k++) feed(NOPW, "R1", s);
      feed(32'h06010000, "R1", s);
      one_cycle(32'h01020101, "R1", st);
      check(st == 1'b1, "R1", "stall before reset", {31'd0, st}, 32'd1);
      @(negedge clk);
      rst = 1'b1;
      fetch_word = 32'h01020101;
      @(posedge clk);
      model_clear();
      @(negedge clk);
      rst = 1'b0;
      #1;
      check(stall == 1'b0, "R1", "stall after mid-stall reset", {31'd0, stall}, 32'd0);
      check(issue_word == 32'h01020101, "R1", "issue after mid-stall reset",
            issue_word, 32'h01020101);
      s = 0;
      feed(32'h01020101, "R1", s);
      check(s == 0, "R1", "no bubble after reset", s, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule